// File: doc/BRIEF.md
# Hash Accelerator Register Bridge

This block puts a 32-bit word-addressed register map in front of a SHA-224/SHA-256 compression core. Software on a simple chip-select bus loads sixteen message words, which the bridge packs into the 512-bit block seen by the core. A control write then sends the core a one-cycle start command: begin a new message, or continue with the following block. A mode bit chooses between the 224-bit and 256-bit digest.

Software polls a status word that mirrors the core's ready and digest-valid flags. The 256-bit digest can then be read as eight words. Longer messages are handled by loading each later block and issuing a continue command, as many times as needed. The digest from the last block stays readable between blocks. The bridge also returns two fixed name words and a version word. It flags accesses that the map does not permit.

Top module: `hash_reg_bridge`

## Requirements
- R1: Reads at 0x00 and 0x01 return the fixed name words "hash" and "-256". A read at 0x02 returns the version word "0.90". Each word holds four ASCII characters, and the first character is in bits 31:24.
- R2: A write to 0x08 with bit 0 set drives core_init high for exactly the one cycle after the write edge. Bit 1 does the same for core_next. Bits 0 and 1 of 0x08 always read back as 0.
- R3: Bit 2 of a write to 0x08 is kept as the mode (1 = 256-bit, 0 = 224-bit) and drives core_mode. It reads back at bit 2 of 0x08. Only a new control write or reset changes it.
- R4: A read at 0x09 returns core_ready in bit 0 and core_digest_ok in bit 1. All other bits are zero.
- R5: A write to 0x10+i (i = 0..15) loads core_block[511-32i : 480-32i]. A read of that address returns the stored word.
- R6: Whenever core_digest_ok is high at a clock edge, the digest is captured. A read at 0x20+i (i = 0..7) returns bits [255-32i : 224-32i] of the captured value. While core_digest_ok is low, the captured value does not change.
- R7: bus_err is high for exactly the cycle after an illegal access and low otherwise. An illegal access is a write to any address other than 0x08 and 0x10..0x1F, or a read from an address outside 0x00..0x02, 0x08, 0x09 and 0x10..0x27. An illegal write changes no state. A read of an unmapped address returns zero.
- R8: Pulling rst_n low clears the block, the mode, both command pulses, the captured digest and bus_err at once, without waiting for a clock edge.
- R9: bus_rdata is zero whenever no read is in progress (bus_sel low, or bus_wr high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | One-cycle illegal-access flag |
| core_init | output | 1 | New-message command pulse |
| core_next | output | 1 | Next-block command pulse |
| core_mode | output | 1 | 1 = 256-bit digest, 0 = 224-bit digest |
| core_block | output | 512 | Assembled message block |
| core_ready | input | 1 | Core idle flag |
| core_digest | input | 256 | Core digest output |
| core_digest_ok | input | 1 | Core digest valid |

## Verification
A wrong word index in the block or digest path shows up at once: either core_block differs on the cycle after the write, or a read of the mapped address returns the wrong slice. A command pulse that sticks or never fires can be seen on core_init or core_next one cycle after the control write. A corrupted mode bit only appears when 0x08 is read back or on core_mode. A digest that is captured while core_digest_ok is low stays hidden until a later read of the digest words. For that reason the random stimulus moves the core digest both with and without the valid flag before it reads back.

// File: rtl/hash_reg_bridge.sv
`timescale 1ns/1ps
module hash_reg_bridge #(
  parameter logic [31:0] ID_WORD0 = 32'h68617368,
  parameter logic [31:0] ID_WORD1 = 32'h2d323536,
  parameter logic [31:0] ID_REV   = 32'h302e3930
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [7:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic         bus_err,
  output logic         core_init,
  output logic         core_next,
  output logic         core_mode,
  output logic [511:0] core_block,
  input  logic         core_ready,
  input  logic [255:0] core_digest,
  input  logic         core_digest_ok
);

  localparam logic [7:0] A_ID0  = 8'h00;
  localparam logic [7:0] A_ID1  = 8'h01;
  localparam logic [7:0] A_REV  = 8'h02;
  localparam logic [7:0] A_CTRL = 8'h08;
  localparam logic [7:0] A_STAT = 8'h09;

  logic [255:0] dig_q;

  wire do_wr  = bus_sel & bus_wr;
  wire do_rd  = bus_sel & ~bus_wr;
  wire in_blk = (bus_addr[7:4] == 4'h1);
  wire in_dig = (bus_addr[7:3] == 5'b00100);
  wire is_ctl = (bus_addr == A_CTRL);
  wire is_id  = (bus_addr == A_ID0) | (bus_addr == A_ID1) | (bus_addr == A_REV);
  wire wr_ok  = is_ctl | in_blk;
  wire rd_ok  = is_id | is_ctl | (bus_addr == A_STAT) | in_blk | in_dig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_init <= 1'b0;
      core_next <= 1'b0;
      core_mode <= 1'b0;
    end else begin
      core_init <= 1'b0;
      core_next <= 1'b0;
      if (do_wr && is_ctl) begin
        core_init <= bus_wdata[0];
        core_next <= bus_wdata[1];
        core_mode <= bus_wdata[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      core_block <= '0;
    else if (do_wr && in_blk)
      core_block[{~bus_addr[3:0], 5'b0} +: 32] <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dig_q <= '0;
    else if (core_digest_ok)
      dig_q <= core_digest;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_err <= 1'b0;
    else
      bus_err <= (do_wr & ~wr_ok) | (do_rd & ~rd_ok);
  end

  always_comb begin
    bus_rdata = '0;
    if (do_rd) begin
      if (in_blk)
        bus_rdata = core_block[{~bus_addr[3:0], 5'b0} +: 32];
      else if (in_dig)
        bus_rdata = dig_q[{~bus_addr[2:0], 5'b0} +: 32];
      else begin
        case (bus_addr)
          A_ID0:   bus_rdata = ID_WORD0;
          A_ID1:   bus_rdata = ID_WORD1;
          A_REV:   bus_rdata = ID_REV;
          A_CTRL:  bus_rdata = {29'b0, core_mode, 2'b00};
          A_STAT:  bus_rdata = {30'b0, core_digest_ok, core_ready};
          default: bus_rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/hash_reg_bridge_chk.sv
`timescale 1ns/1ps
module hash_reg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        bus_err,
  input logic        core_init,
  input logic        core_next,
  input logic        core_mode,
  input logic        core_ready,
  input logic        core_digest_ok
);
  wire rd  = bus_sel && !bus_wr;
  wire ctw = bus_sel && bus_wr && bus_addr == 8'h08;
  wire unmapped = !(bus_addr <= 8'h02 || bus_addr == 8'h08 || bus_addr == 8'h09 ||
                   (bus_addr >= 8'h10 && bus_addr <= 8'h27));

  assert_init_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_init |-> $past(ctw && bus_wdata[0]));
  assert_next_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_next |-> $past(ctw && bus_wdata[1]));
  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctw |=> $stable(core_mode));
  assert_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == 8'h09) |-> bus_rdata == {30'b0, core_digest_ok, core_ready});
  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel));
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && unmapped) |-> bus_rdata == 32'h0);
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> bus_rdata == 32'h0);
endmodule

bind hash_reg_bridge hash_reg_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_err(bus_err), .core_init(core_init), .core_next(core_next),
  .core_mode(core_mode), .core_ready(core_ready), .core_digest_ok(core_digest_ok)
);

// File: tb/sim_hash_reg_bridge.sv
`timescale 1ns/1ps
module sim_hash_reg_bridge;
  logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_err, core_init, core_next, core_mode;
  logic [511:0] core_block;
  logic core_ready = 0, core_digest_ok = 0;
  logic [255:0] core_digest = 0;

  hash_reg_bridge u0 (.*);

  always #2.5 clk = ~clk;

  int nvec = 0, nbad = 0;
  logic [511:0] m_blk = 0;
  logic [255:0] m_dig = 0;
  logic m_mode = 0;
  logic [31:0] rd_val;
  logic rd_err, wr_err, wr_init, wr_next;

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic wr_legal(logic [7:0] a);
    return a == 8'h08 || (a >= 8'h10 && a <= 8'h1f);
  endfunction

  function automatic logic rd_legal(logic [7:0] a);
    return a <= 8'h02 || a == 8'h08 || a == 8'h09 || (a >= 8'h10 && a <= 8'h27);
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    int i;
    if (a == 8'h00) return "hash";
    if (a == 8'h01) return "-256";
    if (a == 8'h02) return "0.90";
    if (a == 8'h08) return {29'b0, m_mode, 2'b00};
    if (a == 8'h09) return {30'b0, core_digest_ok, core_ready};
    if (a >= 8'h10 && a <= 8'h1f) begin i = int'(a) - 16; return m_blk[511-32*i -: 32]; end
    if (a >= 8'h20 && a <= 8'h27) begin i = int'(a) - 32; return m_dig[255-32*i -: 32]; end
    return 32'h0;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    wr_err = bus_err; wr_init = core_init; wr_next = core_next;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 rd_val = bus_rdata;
    @(negedge clk); bus_sel = 0;
    rd_err = bus_err;
  endtask

  task automatic drive_core(logic rdy, logic ok, logic [255:0] d);
    @(negedge clk); core_ready = rdy; core_digest_ok = ok; core_digest = d;
    if (ok) m_dig = d;
    @(negedge clk); core_digest_ok = 0;
  endtask

  task automatic do_ctrl(logic [2:0] c);
    wr(8'h08, {$urandom, 3'b0} | 32'(c));
    m_mode = c[2];
    chk("R2 init pulse", 512'(wr_init), 512'(c[0]));
    chk("R2 next pulse", 512'(wr_next), 512'(c[1]));
    chk("R3 mode out", 512'(core_mode), 512'(c[2]));
    @(negedge clk);
    chk("R2 pulse ends", 512'({core_init, core_next}), 512'(0));
    rd(8'h08);
    chk("R3 ctrl readback", 512'(rd_val), 512'(exp_read(8'h08)));
  endtask

  initial begin
    #(5.0 * 150000);
    nbad++;
    $display("FAIL watchdog (R1..R9 run) act=hung exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7719));
    #12 rst_n = 1;
    // reset state R8
    @(negedge clk);
    chk("R8 reset block", core_block, 512'(0));
    chk("R8 reset outs", 512'({core_init, core_next, core_mode, bus_err}), 512'(0));
    chk("R9 idle rdata", 512'(bus_rdata), 512'(0));
    rd(8'h20);
    chk("R8 reset digest", 512'(rd_val), 512'(0));
    // ID words R1
    for (int a = 0; a < 3; a++) begin
      rd(8'(a));
      chk("R1 id word", 512'(rd_val), 512'(exp_read(8'(a))));
      chk("R1 id no err", 512'(rd_err), 512'(0));
    end
    // directed: first and last block word R5
    wr(8'h10, 32'hdeadbeef); m_blk[511:480] = 32'hdeadbeef;
    chk("R5 word0 slice", core_block, m_blk);
    wr(8'h1f, 32'h0000_01c0); m_blk[31:0] = 32'h0000_01c0;
    chk("R5 word15 slice", core_block, m_blk);
    // chained commands R2 R3
    do_ctrl(3'b101);
    do_ctrl(3'b010);
    do_ctrl(3'b110);
    do_ctrl(3'b000);
    // digest capture/hold R6
    drive_core(1, 1, {8{32'h1234_5678}} ^ 256'h01);
    rd(8'h27);
    chk("R6 last digest word", 512'(rd_val), 512'(exp_read(8'h27)));
    drive_core(1, 0, '1);
    rd(8'h20);
    chk("R6 hold without valid", 512'(rd_val), 512'(exp_read(8'h20)));
    // status R4 with valid held high across the read
    @(negedge clk); core_ready = 0; core_digest_ok = 1; core_digest = m_dig;
    rd(8'h09);
    chk("R4 status valid", 512'(rd_val), 512'(32'h2));
    core_digest_ok = 0; core_ready = 1;
    rd(8'h09);
    chk("R4 status ready", 512'(rd_val), 512'(32'h1));
    // illegal accesses R7
    wr(8'h09, 32'hffff_ffff);
    chk("R7 write status err", 512'(wr_err), 512'(1));
    @(negedge clk);
    chk("R7 err one cycle", 512'(bus_err), 512'(0));
    rd(8'h30);
    chk("R7 unmapped read zero", 512'(rd_val), 512'(0));
    chk("R7 unmapped read err", 512'(rd_err), 512'(1));
    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom % 5);
      case (op)
        0: begin
          int i = int'($urandom % 16);
          logic [31:0] d = $urandom;
          wr(8'(16 + i), d); m_blk[511-32*i -: 32] = d;
          chk("R5 block write", core_block, m_blk);
          chk("R7 legal write no err", 512'(wr_err), 512'(0));
        end
        1: begin
          logic [7:0] a = 8'($urandom % 48);
          rd(a);
          chk("R1 R4 R5 R6 R7 read", 512'(rd_val), 512'(exp_read(a)));
          chk("R7 read err", 512'(rd_err), 512'(!rd_legal(a)));
        end
        2: begin
          logic [7:0] a = 8'($urandom);
          while (wr_legal(a)) a = 8'($urandom);
          wr(a, $urandom);
          chk("R7 illegal write err", 512'(wr_err), 512'(1));
          chk("R7 illegal write no effect", {core_block, 511'(0), core_mode} , {m_blk, 511'(0), m_mode});
        end
        3: begin
          logic [7:0] a = 8'(32 + $urandom % 8);
          drive_core(1'($urandom), 1'($urandom), {$urandom, $urandom, $urandom, $urandom,
                                                   $urandom, $urandom, $urandom, $urandom});
          rd(a);
          chk("R6 digest word", 512'(rd_val), 512'(exp_read(a)));
        end
        default: do_ctrl(3'($urandom));
      endcase
    end
    // asynchronous reset mid-run R8
    @(negedge clk); #1 rst_n = 0;
    #0.5;
    chk("R8 async clear block", core_block, 512'(0));
    chk("R8 async clear mode", 512'(core_mode), 512'(0));
    m_blk = 0; m_mode = 0; m_dig = 0;
    @(negedge clk); rst_n = 1;
    rd(8'h23);
    chk("R8 digest cleared", 512'(rd_val), 512'(0));
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule